// File: doc/BRIEF.md
# Card Status Change Interrupt Unit

This block watches the live pins of one removable-card slot: a pair of card-detect inputs, a pair of battery-voltage inputs, write protect, ready/busy and a power-good flag. Every pin is brought into the clock domain through a synchroniser. The block then reports the pins as a live status byte, keeps a sticky record of the events that matter (card inserted or removed, battery entering the warning or the dead state), and raises an interrupt when an event whose enable is set has been recorded.

Software reaches the unit through a byte-wide indexed register port. The two top index bits pick the slot: bit 7 is the controller number and bit 6 is the slot number. The low six bits pick a register. A read of the change register returns the recorded events and clears them. The configuration register holds the per-event enables. It also holds a 4-bit routing number, which the unit presents on `irq_num` so that a system interrupt line can be chosen from it.

Top module: `card_status_irq`

## Requirements
- R1: The status register at offset 0x01 reads {0, pwr_good, rdy_pin, wp_pin, cd_pin[1:0], bvd_pin[1:0]} (bit 7 down to bit 0). A pin change shows in it two clock edges after the pin moves.
- R2: The card counts as present only when both card-detect pins are 1. Every rise or fall of that combined signal sets bit 3 of the change register. A change on a single pin that leaves the combined value unchanged sets nothing.
- R3: The battery pins decode as follows: 2'b11 is good, 2'b01 is warning, 2'b00 and 2'b10 are dead. Entering warning from another state sets change bit 1. Entering dead from a non-dead state sets change bit 0. Entering good, or moving between the two dead codes, sets nothing.
- R4: Change bits stay set until software reads the change register at offset 0x04. The read returns the current value and clears the register at the following edge. If an event arrives in the same cycle as the clearing read, its bit is kept set.
- R5: The configuration register is at offset 0x05. Bits 7:4 hold the routing number, which appears on irq_num. Bit 3 enables card-detect events, bit 1 enables battery-warning events and bit 0 enables battery-dead events. Bit 2 always reads 0.
- R6: irq_req is high exactly while some change bit is set and its matching enable bit is also set.
- R7: An index whose bits 7:6 differ from {CTRL_ID, SLOT_ID} reads 0x00, writes nothing and clears nothing. Writes to the status register and to the change register have no effect.
- R8: After reset the change register and the configuration register are 0, and irq_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_pin | input | 2 | Card-detect pins |
| bvd_pin | input | 2 | Battery-voltage detect pins |
| wp_pin | input | 1 | Write-protect pin |
| rdy_pin | input | 1 | Ready/busy pin |
| pwr_good | input | 1 | Slot power good |
| reg_idx | input | 8 | Register index (slot tag and offset) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (change register clears on read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the index |
| irq_req | output | 1 | Interrupt request |
| irq_num | output | 4 | Routing number from the configuration register |

## Verification
The hardest case to produce is a clearing read of the change register that lands in the very cycle an event is being recorded. The bench times the pin change so that the read strobe falls exactly two edges after the synchroniser picks up the pin. That read must return the old value, and the next read must still show the event. The bench also covers an event that was recorded while its enable was off and is enabled later, which must raise the interrupt at once. A read through the wrong slot tag must leave a pending event untouched.

// File: rtl/cscu_pkg.sv
package cscu_pkg;

  typedef enum logic [1:0] {
    BATT_DEAD = 2'd0,
    BATT_WARN = 2'd1,
    BATT_GOOD = 2'd2
  } batt_e;

  localparam int          OFS_W      = 6;
  localparam logic [5:0]  OFS_STATUS = 6'h01;
  localparam logic [5:0]  OFS_CHANGE = 6'h04;
  localparam logic [5:0]  OFS_CONFIG = 6'h05;

  localparam int          CHG_W      = 4;
  localparam int          CHG_CD     = 3;
  localparam int          CHG_WARN   = 1;
  localparam int          CHG_DEAD   = 0;

  // writable configuration bits: routing nibble, cd/warn/dead enables
  localparam logic [7:0]  CFG_MASK   = 8'hFB;

  function automatic batt_e batt_decode(input logic [1:0] code);
    case (code)
      2'b11:   batt_decode = BATT_GOOD;
      2'b01:   batt_decode = BATT_WARN;
      default: batt_decode = BATT_DEAD;
    endcase
  endfunction

endpackage

// File: rtl/cscu_sync.sv
module cscu_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d_async;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/cscu_event.sv
module cscu_event
  import cscu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cd_s,
  input  logic [1:0] bvd_s,
  output logic       present,
  output logic       ev_cd,
  output logic       ev_warn,
  output logic       ev_dead
);

  logic  present_q;
  batt_e batt_now, batt_q;

  always_comb begin
    present  = &cd_s;
    batt_now = batt_decode(bvd_s);
    ev_cd    = present ^ present_q;
    ev_warn  = (batt_now == BATT_WARN) && (batt_q != BATT_WARN);
    ev_dead  = (batt_now == BATT_DEAD) && (batt_q != BATT_DEAD);
  end

  // reset state matches the all-zero synchroniser output: absent, dead
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= 1'b0;
      batt_q    <= BATT_DEAD;
    end else begin
      present_q <= present;
      batt_q    <= batt_now;
    end
  end

endmodule

// File: rtl/cscu_regs.sv
module cscu_regs
  import cscu_pkg::*;
#(
  parameter logic [1:0] SLOT_TAG = 2'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_idx,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  input  logic [7:0]       status_byte,
  input  logic             ev_cd,
  input  logic             ev_warn,
  input  logic             ev_dead,
  output logic [7:0]       reg_rdata,
  output logic             idx_hit,
  output logic [CHG_W-1:0] chg_q,
  output logic             irq_req,
  output logic [3:0]       irq_num
);

  logic [OFS_W-1:0] ofs;
  logic [CHG_W-1:0] chg_d, chg_set;
  logic [7:0]       cfg_q, cfg_d;
  logic             cfg_en, chg_clr;

  always_comb begin
    ofs     = reg_idx[OFS_W-1:0];
    idx_hit = (reg_idx[7:6] == SLOT_TAG);
    chg_clr = idx_hit && reg_rd && (ofs == OFS_CHANGE);
    cfg_en  = idx_hit && reg_wr && (ofs == OFS_CONFIG);

    chg_set           = '0;
    chg_set[CHG_CD]   = ev_cd;
    chg_set[CHG_WARN] = ev_warn;
    chg_set[CHG_DEAD] = ev_dead;
    // a new event wins over a clearing read in the same cycle
    chg_d = (chg_clr ? '0 : chg_q) | chg_set;
    cfg_d = reg_wdata & CFG_MASK;

    reg_rdata = 8'h00;
    if (idx_hit) begin
      case (ofs)
        OFS_STATUS: reg_rdata = status_byte;
        OFS_CHANGE: reg_rdata = {4'h0, chg_q};
        OFS_CONFIG: reg_rdata = cfg_q;
        default:    reg_rdata = 8'h00;
      endcase
    end

    irq_req = |(chg_q & cfg_q[CHG_W-1:0]);
    irq_num = cfg_q[7:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= chg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

endmodule

// File: rtl/card_status_irq.sv
module card_status_irq
  import cscu_pkg::*;
#(
  parameter int CTRL_ID     = 0,
  parameter int SLOT_ID     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cd_pin,
  input  logic [1:0] bvd_pin,
  input  logic       wp_pin,
  input  logic       rdy_pin,
  input  logic       pwr_good,
  input  logic [7:0] reg_idx,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_req,
  output logic [3:0] irq_num
);

  localparam int         PIN_W    = 7;
  localparam logic [1:0] SLOT_TAG = {CTRL_ID[0], SLOT_ID[0]};

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [PIN_W-1:0] pins_async, pins_s;
  logic [1:0]       cd_s, bvd_s;
  logic             wp_s, rdy_s, pwr_s;
  logic             present, ev_cd, ev_warn, ev_dead, idx_hit;
  logic [CHG_W-1:0] chg_q;
  logic [7:0]       status_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign pins_async = {pwr_good, rdy_pin, wp_pin, cd_pin, bvd_pin};

  cscu_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .d_async (pins_async),
    .d_sync  (pins_s)
  );

  assign {pwr_s, rdy_s, wp_s, cd_s, bvd_s} = pins_s;
  assign status_byte = {1'b0, pwr_s, rdy_s, wp_s, cd_s, bvd_s};

  cscu_event i_event (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cd_s    (cd_s),
    .bvd_s   (bvd_s),
    .present (present),
    .ev_cd   (ev_cd),
    .ev_warn (ev_warn),
    .ev_dead (ev_dead)
  );

  cscu_regs #(.SLOT_TAG(SLOT_TAG)) i_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reg_idx     (reg_idx),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .status_byte (status_byte),
    .ev_cd       (ev_cd),
    .ev_warn     (ev_warn),
    .ev_dead     (ev_dead),
    .reg_rdata   (reg_rdata),
    .idx_hit     (idx_hit),
    .chg_q       (chg_q),
    .irq_req     (irq_req),
    .irq_num     (irq_num)
  );

endmodule

// File: rtl/card_status_irq_chk.sv
module card_status_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] reg_ofs,
  input logic       idx_hit,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       present,
  input logic       ev_cd,
  input logic       ev_warn,
  input logic       ev_dead,
  input logic [3:0] chg_q,
  input logic       irq_req,
  input logic [3:0] irq_num
);

  logic rd_chg, wr_cfg;
  assign rd_chg = idx_hit && reg_rd && (reg_ofs == 6'h04);
  assign wr_cfg = idx_hit && reg_wr && (reg_ofs == 6'h05);

  assert_cd_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (present != $past(present)) |-> ##1 chg_q[3]);

  assert_batt_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_warn && ev_dead));

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_q[3] && !rd_chg) |=> chg_q[3]);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chg && !ev_cd && !ev_warn && !ev_dead) |=> (chg_q == 4'h0));

  assert_cfg_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cfg |=> (irq_num == $past(reg_wdata[7:4])));

  assert_irq_needs_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (chg_q != 4'h0));

  assert_foreign_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_hit |-> (reg_rdata == 8'h00));

endmodule

bind card_status_irq card_status_irq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_ofs   (reg_idx[5:0]),
  .idx_hit   (idx_hit),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .present   (present),
  .ev_cd     (ev_cd),
  .ev_warn   (ev_warn),
  .ev_dead   (ev_dead),
  .chg_q     (chg_q),
  .irq_req   (irq_req),
  .irq_num   (irq_num)
);

// File: tb/test_card_status_irq.sv
`timescale 1ns/1ps
module test_card_status_irq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cd_pin, bvd_pin;
  logic       wp_pin, rdy_pin, pwr_good;
  logic [7:0] reg_idx, reg_wdata;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [3:0] irq_num;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  card_status_irq i_card_status_irq (
    .clk(clk), .rst_n(rst_n), .cd_pin(cd_pin), .bvd_pin(bvd_pin),
    .wp_pin(wp_pin), .rdy_pin(rdy_pin), .pwr_good(pwr_good),
    .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_num(irq_num)
  );

  // monitor: compare read data against the scoreboard mid-cycle
  always @(negedge clk) begin
    if (reg_rd && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: rdata actual 0x%02h expected 0x%02h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic do_read(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    reg_idx = idx; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] data);
    @(posedge clk); #1;
    reg_idx = idx; reg_wdata = data; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic set_pins(input logic pw, input logic rd, input logic wp,
                          input logic [1:0] cd, input logic [1:0] bv);
    @(posedge clk); #1;
    pwr_good = pw; rdy_pin = rd; wp_pin = wp; cd_pin = cd; bvd_pin = bv;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    @(negedge clk);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sts(input logic pw, input logic rd, input logic wp,
                                     input logic [1:0] cd, input logic [1:0] bv);
    return {1'b0, pw, rd, wp, cd, bv};
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_idx = 0; reg_wdata = 0;
    cd_pin = 0; bvd_pin = 0; wp_pin = 0; rdy_pin = 0; pwr_good = 0;
    settle(3); #1 rst_n = 1'b1;
    settle(4);

    // R8 reset state
    do_read(8'h41, 8'h00, "R8 status");
    do_read(8'h44, 8'h00, "R8 change");
    do_read(8'h45, 8'h00, "R8 config");
    chk_bit(irq_req, 1'b0, "R8 irq_req");

    // R1 status layout, R3 good battery raises nothing
    set_pins(1, 1, 1, 2'b00, 2'b11); settle(4);
    do_read(8'h41, sts(1, 1, 1, 2'b00, 2'b11), "R1 status");
    do_read(8'h44, 8'h00, "R3 good no event");

    // R2 single pin is not a card
    set_pins(1, 1, 1, 2'b01, 2'b11); settle(4);
    do_read(8'h41, sts(1, 1, 1, 2'b01, 2'b11), "R1 status cd01");
    do_read(8'h44, 8'h00, "R2 single pin");

    // R2 insertion, R4 clear on read
    set_pins(1, 1, 1, 2'b11, 2'b11); settle(4);
    do_read(8'h44, 8'h08, "R2 insert");
    do_read(8'h44, 8'h00, "R4 cleared");

    // R5 configuration
    do_write(8'h45, 8'hFF);
    do_read(8'h45, 8'hFB, "R5 bit2 zero");
    chk_bit(irq_num == 4'hF, 1'b1, "R5 irq_num F");
    do_write(8'h45, 8'h58);
    do_read(8'h45, 8'h58, "R5 readback");
    chk_bit(irq_num == 4'h5, 1'b1, "R5 irq_num 5");

    // R2 removal, R6 interrupt follows enabled bit
    set_pins(1, 1, 1, 2'b10, 2'b11); settle(4);
    chk_bit(irq_req, 1'b1, "R6 irq on removal");
    do_read(8'h44, 8'h08, "R2 removal");
    chk_bit(irq_req, 1'b0, "R6 irq after clear");

    // R3 battery transitions
    set_pins(1, 1, 1, 2'b10, 2'b01); settle(4);
    chk_bit(irq_req, 1'b0, "R6 warn disabled");
    do_read(8'h44, 8'h02, "R3 warning");
    set_pins(1, 1, 1, 2'b10, 2'b00); settle(4);
    do_read(8'h44, 8'h01, "R3 dead");
    set_pins(1, 1, 1, 2'b10, 2'b10); settle(4);
    do_read(8'h44, 8'h00, "R3 dead to dead");

    // R4 sticky while disabled, R6 late enable
    set_pins(1, 1, 1, 2'b10, 2'b11); settle(4);
    set_pins(1, 1, 1, 2'b10, 2'b01); settle(10);
    chk_bit(irq_req, 1'b0, "R6 pending but masked");
    do_write(8'h45, 8'h52);
    chk_bit(irq_req, 1'b1, "R6 late enable");
    do_read(8'h44, 8'h02, "R4 sticky warn");

    // R7 foreign slot tags and read-only registers
    set_pins(1, 1, 1, 2'b11, 2'b01); settle(4);
    do_read(8'hC4, 8'h00, "R7 foreign read c4");
    do_read(8'h04, 8'h00, "R7 foreign read 04");
    do_read(8'h44, 8'h08, "R7 event kept");
    do_write(8'h05, 8'hFF);
    do_read(8'h45, 8'h52, "R7 foreign write");
    do_write(8'h41, 8'hFF);
    do_read(8'h41, sts(1, 1, 1, 2'b11, 2'b01), "R7 status ro");
    do_write(8'h44, 8'hFF);
    do_read(8'h44, 8'h00, "R7 change ro");

    // R4 clearing read colliding with a new event
    set_pins(1, 1, 1, 2'b01, 2'b01);
    @(posedge clk);
    do_read(8'h44, 8'h00, "R4 collide old value");
    do_read(8'h44, 8'h08, "R4 collide kept");

    settle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule